// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with MSB-Aligned Word Fitting

This block is the slave end of a three-wire serial audio link. It takes a bit clock, a channel-select line and a serial data line from an external master. It turns the stream into parallel left and right samples in the system clock domain. All three wires are oversampled by a faster system clock. Rising edges of the bit clock are found in that domain, and data and channel select are captured at those edges.

The receiver has a fixed sample width. It never needs to know how many bits the sender puts into a word. Each word is placed MSB-first from the top bit of the output. Bits beyond the receiver's width are thrown away, and positions the sender never filled read as zero. A change on the channel-select line closes the current word. The bit sampled at that same edge is the last bit of the word that is closing. A left word is held until the right word that follows it is complete. The two are then presented together with a single-cycle strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: Serial data and channel select are sampled only at rising edges of the bit clock. Levels present only while the bit clock is low have no effect.
- R2: The first bit of a word lands in the most significant output bit and later bits fill downward. A sender word of exactly the receiver width (16 bits by default) appears unchanged.
- R3: When a sender word is longer than the receiver width, only its first width bits are kept and the rest are discarded.
- R4: When a sender word is shorter than the receiver width, the unfilled low-order output bits are zero.
- R5: Channel select low (0) marks a left word and high (1) marks a right word. A left word appears on `left_o` and a right word on `right_o`.
- R6: A word is closed at the rising edge where channel select differs from its value at the previous rising edge. The data bit sampled at that edge belongs to the closing word, and the next word starts empty.
- R7: After a left word and the following right word are both complete, `valid_o` pulses high for exactly one system clock cycle with both words on the outputs. The outputs hold their values until the next pulse.
- R8: After reset, no pulse is given until a full left word has been received whose first bit followed a channel-select change. A partial word in progress at start-up is dropped, and a right word with no held left word is dropped.
- R9: While reset is active, and after it until the first pulse, `valid_o`, `left_o` and `right_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the link master |
| lrsel_i | input | 1 | Channel select: 0 left, 1 right |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | DATA_W | Left sample of the latest pair |
| right_o | output | DATA_W | Right sample of the latest pair |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
A pair strobe is due five system cycles after the input flop sees the bit-clock rise that carries the right word's closing channel-select change. That count is two synchronizer stages, the edge capture register, the word assembler register and the output register. The monitor does not rely on a fixed offset. It samples on falling system-clock edges and compares each strobe with the oldest expected pair in a queue. The driver pushes that pair before it sends the right word, so the pair is always queued well ahead of the strobe. Dropped start-up words are checked by counting strobes across that stretch. A final check requires the queue to be empty once the link has gone quiet.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/asr_capture.sv
module asr_capture
  import asr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk_s,
  input  logic  ws_s,
  input  logic  sd_s,
  output logic  stb_o,
  output logic  bit_o,
  output logic  flip_o,
  output chan_e chan_o
);
  logic  bclk_q, ws_last_q, ws_seen_q, stb_q, bit_q, flip_q;
  chan_e chan_q;
  logic  ws_last_d, ws_seen_d, stb_d, bit_d, flip_d;
  chan_e chan_d;
  logic  rise;

  assign rise = bclk_s & ~bclk_q;

  always_comb begin
    ws_last_d = ws_last_q;
    ws_seen_d = ws_seen_q;
    stb_d     = 1'b0;
    bit_d     = bit_q;
    flip_d    = 1'b0;
    chan_d    = chan_q;
    if (rise) begin
      stb_d     = 1'b1;
      bit_d     = sd_s;
      flip_d    = ws_seen_q && (ws_s != ws_last_q);
      chan_d    = chan_e'(ws_last_q);
      ws_last_d = ws_s;
      ws_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      ws_last_q <= 1'b0;
      ws_seen_q <= 1'b0;
      stb_q     <= 1'b0;
      bit_q     <= 1'b0;
      flip_q    <= 1'b0;
      chan_q    <= CH_LEFT;
    end else begin
      bclk_q    <= bclk_s;
      ws_last_q <= ws_last_d;
      ws_seen_q <= ws_seen_d;
      stb_q     <= stb_d;
      bit_q     <= bit_d;
      flip_q    <= flip_d;
      chan_q    <= chan_d;
    end
  end

  assign stb_o  = stb_q;
  assign bit_o  = bit_q;
  assign flip_o = flip_q;
  assign chan_o = chan_q;

  // R1: one strobe per bit-clock rise, never on back-to-back cycles
  p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R6: a word boundary is only flagged together with a bit
  p_flip_with_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flip_q |-> stb_q);
endmodule

// File: rtl/asr_word_asm.sv
module asr_word_asm
  import asr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              bit_i,
  input  logic              flip_i,
  input  chan_e             chan_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output chan_e             chan_o,
  output logic              whole_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] FULL   = CW'(DATA_W);
  localparam logic [IW-1:0] TOPIDX = IW'(DATA_W - 1);

  logic [DATA_W-1:0] acc_q, acc_d, acc_w, word_q, word_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              started_q, started_d, done_q, done_d, whole_q, whole_d;
  chan_e             wchan_q, wchan_d;
  logic [IW-1:0]     idx;
  logic              room;

  assign room = (cnt_q < FULL);
  assign idx  = TOPIDX - cnt_q[IW-1:0];

  always_comb begin
    acc_w = acc_q;
    if (room) acc_w[idx] = bit_i;
  end

  always_comb begin
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    started_d = started_q;
    done_d    = 1'b0;
    word_d    = word_q;
    wchan_d   = wchan_q;
    whole_d   = whole_q;
    if (stb_i) begin
      if (flip_i) begin
        done_d    = 1'b1;
        word_d    = acc_w;
        wchan_d   = chan_i;
        whole_d   = started_q;
        acc_d     = '0;
        cnt_d     = '0;
        started_d = 1'b1;
      end else begin
        acc_d = acc_w;
        if (room) cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      done_q    <= 1'b0;
      word_q    <= '0;
      wchan_q   <= CH_LEFT;
      whole_q   <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      cnt_q     <= cnt_d;
      started_q <= started_d;
      done_q    <= done_d;
      word_q    <= word_d;
      wchan_q   <= wchan_d;
      whole_q   <= whole_d;
    end
  end

  assign done_o  = done_q;
  assign word_o  = word_q;
  assign chan_o  = wchan_q;
  assign whole_o = whole_q;

  // R3: the fill counter never passes the receiver width
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R6: a boundary leaves the assembler empty for the next word
  p_clear_on_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && flip_i) |=> (cnt_q == '0 && acc_q == '0));
endmodule

// File: rtl/asr_pair.sv
module asr_pair
  import asr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  chan_e             chan_i,
  input  logic              whole_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] hold_q, hold_d, left_q, left_d, right_q, right_d;
  logic              have_q, have_d, valid_q, valid_d;

  always_comb begin
    hold_d  = hold_q;
    have_d  = have_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (done_i) begin
      if (!whole_i) begin
        have_d = 1'b0;
      end else if (chan_i == CH_LEFT) begin
        hold_d = word_i;
        have_d = 1'b1;
      end else if (have_q) begin
        left_d  = hold_q;
        right_d = word_i;
        valid_d = 1'b1;
        have_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      have_q  <= have_d;
      left_q  <= left_d;
      right_q <= right_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  // R7: strobe lasts a single cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7: outputs only move together with the strobe
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(left_q) && $stable(right_q)));
  // R8: a pair needs a held left word behind it
  p_pair_needs_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && whole_i && chan_i == CH_RIGHT && !have_q) |=> !valid_q);
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrsel_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic [2:0]        raw, synced;
  logic              stb, bitv, flip, done, whole;
  chan_e             bchan, wchan;
  logic [DATA_W-1:0] word;

  assign raw = {bclk_i, lrsel_i, sdata_i};

  asr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
  );

  asr_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(synced[2]), .ws_s(synced[1]), .sd_s(synced[0]),
    .stb_o(stb), .bit_o(bitv), .flip_o(flip), .chan_o(bchan)
  );

  asr_word_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .stb_i(stb), .bit_i(bitv), .flip_i(flip), .chan_i(bchan),
    .done_o(done), .word_o(word), .chan_o(wchan), .whole_o(whole)
  );

  asr_pair #(.DATA_W(DATA_W)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .done_i(done), .word_i(word), .chan_i(wchan), .whole_i(whole),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, lrsel = 1'b1, sdata = 1'b0;
  logic [W-1:0] left_o, right_o;
  logic valid_o;

  int total = 0, bad = 0, pulses = 0;
  logic prev_valid = 1'b0;
  logic [W-1:0] exp_l_q[$], exp_r_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  audio_serial_rx #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrsel_i(lrsel),
    .sdata_i(sdata), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] fit(logic [31:0] d, int len);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) if (i < len) r[W-1-i] = d[len-1-i];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bit period: drive while the bit clock is low, then raise it
  task automatic bit_period(logic d, logic ws);
    @(negedge clk);
    sdata = d; lrsel = ws;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_word(logic ch, logic [31:0] d, int len, logic nxt);
    for (int i = 0; i < len; i++)
      bit_period(d[len-1-i], (i == len-1) ? nxt : ch);
  endtask

  task automatic send_pair(string tag, logic [31:0] l, int ll, logic [31:0] r, int rl);
    exp_l_q.push_back(fit(l, ll));
    exp_r_q.push_back(fit(r, rl));
    tag_q.push_back(tag);
    send_word(1'b0, l, ll, 1'b1);
    send_word(1'b1, r, rl, 1'b0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
    end else begin
      if (prev_valid) chk("R7 strobe width", {31'd0, valid_o}, 32'd0);
      if (valid_o) begin
        pulses++;
        if (exp_l_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R8 unexpected pair actual=%h/%h expected=none", left_o, right_o);
        end else begin
          string t;
          logic [W-1:0] el, er;
          el = exp_l_q.pop_front(); er = exp_r_q.pop_front(); t = tag_q.pop_front();
          chk({t, " left"}, {16'd0, left_o}, {16'd0, el});
          chk({t, " right"}, {16'd0, right_o}, {16'd0, er});
        end
      end
      prev_valid <= valid_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", {31'd0, valid_o}, 32'd0);
    chk("R9 left in reset", {16'd0, left_o}, 32'd0);
    chk("R9 right in reset", {16'd0, right_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 outputs after reset", {15'd0, valid_o, left_o}, 32'd0);
    // partial right word at start-up, then clean pairs
    send_word(1'b1, 32'h5, 3, 1'b0);
    send_pair("R1 R2 R5 exact", 32'hA5C3, 16, 32'h1234, 16);
    send_pair("R3 long", 32'hABCDEF, 24, 32'h123456, 24);
    send_pair("R4 short", 32'h5A7, 12, 32'hC3, 8);
    send_pair("R3 R4 odd", 32'h1FFFF, 17, 32'h1, 1);
    send_pair("R6 lsb at edge", 32'h0001, 16, 32'h8000, 16);
    repeat (4) bit_period(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 held after pair", {16'd0, right_o}, 32'h8000);

    // second run: start inside a left word
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 cleared by reset", {15'd0, valid_o, left_o}, 32'd0);
    lrsel = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = pulses;
    send_word(1'b0, 32'hFFFF, 5, 1'b1);
    send_word(1'b1, 32'h7777, 16, 1'b0);
    repeat (20) @(negedge clk);
    chk("R8 orphan right dropped", pulses, base);
    send_pair("R8 first clean pair", 32'h0F0F, 16, 32'hF0F0, 16);
    repeat (4) bit_period(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 all pairs seen", exp_l_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule